// File: doc/BRIEF.md
# Stacked Register Frame Renamer

This block maps architectural integer register numbers onto indices of a physical register file whose upper part acts as a stack of procedure frames. The lowest 32 registers are shared by every procedure and pass through unchanged. Every register from 32 up is stacked: each procedure sees its own window, which always begins at architectural register 32 and is placed in a 96-entry circular physical region by a frame base pointer.

The current frame marker holds a base, a local-area size and an output-area size. An allocate command resizes the local and output areas of the running frame. A call saves the marker on an internal stack and moves the base past the caller's locals. The callee's register 32 then lands on the caller's first output register, so arguments pass with no data movement. A return restores the saved marker in a single cycle. The physical index, the out-of-frame flag and the gated write enable are combinational from the current marker and the access inputs. Commands take effect at the next rising clock edge.

Top module: `srf_renamer`

## Requirements
- R1: An access to architectural register 0..31 gives physical index equal to the register number and never raises the out-of-frame flag, whatever the frame state.
- R2: An access to architectural register a >= 32 gives physical index 32 + ((base + (a - 32)) mod 96).
- R3: `oof_err` is high exactly when `acc_valid` is high, a >= 32 and (a - 32) >= local size + output size.
- R4: `wr_en` is high exactly when `acc_valid` and `acc_write` are high and `oof_err` is low; out-of-frame writes are suppressed.
- R5: An accepted allocate sets local size to `alloc_loc` and output size to `alloc_out` from the next cycle on, with the base unchanged. If `alloc_loc + alloc_out` exceeds 96, `frame_err` is high in that cycle and the marker is unchanged.
- R6: An accepted call sets the base to (base + local size) mod 96, the local size to 0, and keeps the output size, from the next cycle on.
- R7: An accepted return restores the exact marker saved by the most recent call that has not yet been matched by a return.
- R8: The saved-marker stack holds 8 entries. A call with 8 saved, or a return with none saved, raises `frame_err` in that cycle and leaves the marker and the stack unchanged.
- R9: When commands coincide, return takes precedence over call, and call over allocate. The losing commands have no effect.
- R10: After reset the marker is all zero (base 0, both sizes 0) and the saved-marker stack is empty.
- R11: `cfm_o` shows the current marker with the base in bits [20:14], the local size in bits [13:7] and the output size in bits [6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_arch | input | 7 | Architectural register number |
| call_i | input | 1 | Call pulse |
| ret_i | input | 1 | Return pulse |
| alloc_i | input | 1 | Allocate command |
| alloc_loc | input | 7 | Requested local-area size |
| alloc_out | input | 7 | Requested output-area size |
| phys_idx | output | 7 | Physical register index |
| oof_err | output | 1 | Access beyond the current frame |
| wr_en | output | 1 | Gated write enable to the register file |
| cfm_o | output | 21 | Current frame marker {base, local, output} |
| frame_err | output | 1 | Stack overflow, stack underflow or oversized allocate |

## Verification
The bench nests calls until the 96-entry region wraps. A renamer that forgets the modulo would then give indices above 127 or back into the static range. It probes the last in-frame register and the first out-of-frame one, where an off-by-one size compare would either let a write through or block a legal one. It fills the marker stack to exactly eight, then issues one more call. It also returns on an empty stack, where a design with a wrong pointer would corrupt the marker instead of flagging. Return with call in the same cycle, and call with allocate in the same cycle, show whether the priority order holds. An unwinding sequence shows whether each return restores the right saved marker rather than a neighbour.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int ARCH_W   = 7;
  localparam int SIZE_W   = 7;
  localparam int STATIC_N = 32;
  localparam int STACK_N  = 96;
  localparam int MARK_W   = 3 * SIZE_W;

  typedef struct packed {
    logic [SIZE_W-1:0] base;
    logic [SIZE_W-1:0] nloc;
    logic [SIZE_W-1:0] nout;
  } frame_mark_t;
endpackage

// File: rtl/srf_xlate.sv
module srf_xlate
  import srf_pkg::*;
(
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ARCH_W-1:0] acc_arch,
  input  frame_mark_t       mark,
  output logic [ARCH_W-1:0] phys_idx,
  output logic              oof_err,
  output logic              wr_en
);
  logic              stacked;
  logic [ARCH_W-1:0] offset;
  logic [ARCH_W:0]   sum;
  logic [ARCH_W-1:0] wrapped;
  logic [SIZE_W:0]   fsize;

  always_comb begin
    stacked  = acc_arch >= ARCH_W'(STATIC_N);
    offset   = acc_arch - ARCH_W'(STATIC_N);
    sum      = {1'b0, mark.base} + {1'b0, offset};
    wrapped  = ARCH_W'((sum >= (ARCH_W+1)'(STACK_N)) ? (sum - (ARCH_W+1)'(STACK_N)) : sum);
    fsize    = {1'b0, mark.nloc} + {1'b0, mark.nout};
    phys_idx = stacked ? (ARCH_W'(STATIC_N) + wrapped) : acc_arch;
    oof_err  = acc_valid && stacked && ({1'b0, offset} >= fsize);
    wr_en    = acc_valid && acc_write && !oof_err;
  end
endmodule

// File: rtl/srf_mark_stack.sv
module srf_mark_stack
  import srf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic        pop,
  input  frame_mark_t push_mark,
  output frame_mark_t top_mark,
  output logic        full,
  output logic        empty
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  frame_mark_t   mem [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && (cnt_q == PW'(gi))) begin
          mem[gi] <= push_mark;
        end
      end
    end
  endgenerate

  always_comb begin
    top_mark = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == PW'(i + 1)) top_mark = mem[i];
    end
    full  = cnt_q == PW'(DEPTH);
    empty = cnt_q == '0;
    cnt_d = cnt_q;
    if (push)     cnt_d = cnt_q + PW'(1);
    else if (pop) cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (push || pop) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/srf_frame_ctl.sv
module srf_frame_ctl
  import srf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              alloc_i,
  input  logic [SIZE_W-1:0] alloc_loc,
  input  logic [SIZE_W-1:0] alloc_out,
  input  logic              st_full,
  input  logic              st_empty,
  input  frame_mark_t       top_mark,
  output frame_mark_t       cur_mark,
  output logic              push,
  output logic              pop,
  output logic              frame_err
);
  frame_mark_t     mark_q, mark_d;
  logic            mark_en;
  logic [SIZE_W:0] nbase;
  logic [SIZE_W:0] asize;

  always_comb begin
    mark_d    = mark_q;
    mark_en   = 1'b0;
    push      = 1'b0;
    pop       = 1'b0;
    frame_err = 1'b0;
    nbase     = {1'b0, mark_q.base} + {1'b0, mark_q.nloc};
    asize     = {1'b0, alloc_loc} + {1'b0, alloc_out};
    if (ret_i) begin
      if (st_empty) begin
        frame_err = 1'b1;
      end else begin
        pop     = 1'b1;
        mark_en = 1'b1;
        mark_d  = top_mark;
      end
    end else if (call_i) begin
      if (st_full) begin
        frame_err = 1'b1;
      end else begin
        push        = 1'b1;
        mark_en     = 1'b1;
        mark_d.base = SIZE_W'((nbase >= (SIZE_W+1)'(STACK_N)) ? (nbase - (SIZE_W+1)'(STACK_N)) : nbase);
        mark_d.nloc = '0;
        mark_d.nout = mark_q.nout;
      end
    end else if (alloc_i) begin
      if (asize > (SIZE_W+1)'(STACK_N)) begin
        frame_err = 1'b1;
      end else begin
        mark_en     = 1'b1;
        mark_d.nloc = alloc_loc;
        mark_d.nout = alloc_out;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= '0;
    end else if (mark_en) begin
      mark_q <= mark_d;
    end
  end

  assign cur_mark = mark_q;
endmodule

// File: rtl/srf_renamer.sv
module srf_renamer
  import srf_pkg::*;
#(
  parameter int MARK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ARCH_W-1:0] acc_arch,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              alloc_i,
  input  logic [SIZE_W-1:0] alloc_loc,
  input  logic [SIZE_W-1:0] alloc_out,
  output logic [ARCH_W-1:0] phys_idx,
  output logic              oof_err,
  output logic              wr_en,
  output logic [MARK_W-1:0] cfm_o,
  output logic              frame_err
);
  logic        rst_meta_q, rst_n_s;
  frame_mark_t cur_mark, top_mark;
  logic        push, pop, st_full, st_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  srf_frame_ctl i_ctl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .alloc_i   (alloc_i),
    .alloc_loc (alloc_loc),
    .alloc_out (alloc_out),
    .st_full   (st_full),
    .st_empty  (st_empty),
    .top_mark  (top_mark),
    .cur_mark  (cur_mark),
    .push      (push),
    .pop       (pop),
    .frame_err (frame_err)
  );

  srf_mark_stack #(.DEPTH(MARK_DEPTH)) i_stack (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push      (push),
    .pop       (pop),
    .push_mark (cur_mark),
    .top_mark  (top_mark),
    .full      (st_full),
    .empty     (st_empty)
  );

  srf_xlate i_xlate (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_arch  (acc_arch),
    .mark      (cur_mark),
    .phys_idx  (phys_idx),
    .oof_err   (oof_err),
    .wr_en     (wr_en)
  );

  assign cfm_o = cur_mark;
endmodule

// File: rtl/srf_renamer_chk.sv
module srf_renamer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [6:0]  acc_arch,
  input logic        call_i,
  input logic        ret_i,
  input logic        alloc_i,
  input logic [6:0]  alloc_loc,
  input logic [6:0]  alloc_out,
  input logic [6:0]  phys_idx,
  input logic        oof_err,
  input logic        wr_en,
  input logic [20:0] cfm_o,
  input logic        frame_err
);
  logic [6:0] c_base, c_loc, c_out;
  assign c_base = cfm_o[20:14];
  assign c_loc  = cfm_o[13:7];
  assign c_out  = cfm_o[6:0];

  AST_STATIC_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_arch < 7'd32) |-> (phys_idx == acc_arch && !oof_err)); // R1

  AST_STACKED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_arch >= 7'd32) |-> (phys_idx >= 7'd32)); // R2

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    oof_err |-> !wr_en); // R4

  AST_ALLOC_SIZES: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !call_i && !ret_i && !frame_err) |=>
      (c_loc == $past(alloc_loc) && c_out == $past(alloc_out) && $stable(c_base))); // R5

  AST_CALL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && !frame_err) |=>
      (c_loc == 7'd0 && $stable(c_out) &&
       c_base == 7'((({1'b0, $past(c_base)} + {1'b0, $past(c_loc)}) % 8'd96)))); // R6

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> $stable(cfm_o)); // R8
endmodule

bind srf_renamer srf_renamer_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_arch  (acc_arch),
  .call_i    (call_i),
  .ret_i     (ret_i),
  .alloc_i   (alloc_i),
  .alloc_loc (alloc_loc),
  .alloc_out (alloc_out),
  .phys_idx  (phys_idx),
  .oof_err   (oof_err),
  .wr_en     (wr_en),
  .cfm_o     (cfm_o),
  .frame_err (frame_err)
);

// File: tb/test_srf_renamer.sv
module test_srf_renamer;
  logic        clk, rst_n;
  logic        acc_valid, acc_write, call_i, ret_i, alloc_i;
  logic [6:0]  acc_arch, alloc_loc, alloc_out;
  logic [6:0]  phys_idx;
  logic        oof_err, wr_en, frame_err;
  logic [20:0] cfm_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    phys;
    bit    oof;
    bit    wr;
    int    cfm;
    bit    ferr;
    string tag;
  } exp_t;
  exp_t q[$];

  int m_base, m_loc, m_out, sp;
  int sb[8];
  int sl[8];
  int so[8];

  srf_renamer i_srf_renamer (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_arch(acc_arch), .call_i(call_i), .ret_i(ret_i), .alloc_i(alloc_i),
    .alloc_loc(alloc_loc), .alloc_out(alloc_out), .phys_idx(phys_idx),
    .oof_err(oof_err), .wr_en(wr_en), .cfm_o(cfm_o), .frame_err(frame_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit c, input bit r, input bit a, input int al, input int ao,
                      input bit v, input bit w, input int arch, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    call_i = c; ret_i = r; alloc_i = a;
    alloc_loc = 7'(al); alloc_out = 7'(ao);
    acc_valid = v; acc_write = w; acc_arch = 7'(arch);
    e.tag  = tag;
    e.cfm  = (m_base << 14) | (m_loc << 7) | m_out;
    e.phys = (arch < 32) ? arch : 32 + ((m_base + arch - 32) % 96);
    e.oof  = v && (arch >= 32) && ((arch - 32) >= (m_loc + m_out));
    e.wr   = v && w && !e.oof;
    if (r)      e.ferr = (sp == 0);
    else if (c) e.ferr = (sp == 8);
    else if (a) e.ferr = (al + ao > 96);
    else        e.ferr = 1'b0;
    q.push_back(e);
    if (r) begin
      if (sp > 0) begin
        sp--; m_base = sb[sp]; m_loc = sl[sp]; m_out = so[sp];
      end
    end else if (c) begin
      if (sp < 8) begin
        sb[sp] = m_base; sl[sp] = m_loc; so[sp] = m_out; sp++;
        m_base = (m_base + m_loc) % 96; m_loc = 0;
      end
    end else if (a) begin
      if (al + ao <= 96) begin
        m_loc = al; m_out = ao;
      end
    end
  endtask

  task automatic acc(input bit w, input int arch, input string tag);
    step(0, 0, 0, 0, 0, 1, w, arch, tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(int'(phys_idx) == e.phys, e.tag, "phys_idx", int'(phys_idx), e.phys);
      chk(oof_err == e.oof, e.tag, "oof_err", int'(oof_err), int'(e.oof));
      chk(wr_en == e.wr, e.tag, "wr_en", int'(wr_en), int'(e.wr));
      chk(int'(cfm_o) == e.cfm, {e.tag, " R11"}, "cfm_o", int'(cfm_o), e.cfm);
      chk(frame_err == e.ferr, e.tag, "frame_err", int'(frame_err), int'(e.ferr));
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_base = 0; m_loc = 0; m_out = 0; sp = 0;
    rst_n = 1'b0;
    call_i = 0; ret_i = 0; alloc_i = 0; alloc_loc = 0; alloc_out = 0;
    acc_valid = 0; acc_write = 0; acc_arch = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    acc(0, 5, "R10 reset static");
    acc(1, 32, "R10 R3 empty frame");
    step(0, 0, 1, 4, 3, 1, 0, 3, "R5 alloc R1");
    acc(1, 38, "R4 last in frame");
    acc(1, 39, "R3 R4 first out of frame");
    acc(0, 34, "R2 map");
    acc(1, 31, "R1 top static");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R6 call");
    acc(1, 32, "R6 callee r32 on caller output");
    acc(0, 34, "R6 last output");
    acc(1, 35, "R3 callee beyond outputs");
    step(0, 0, 1, 10, 2, 0, 0, 0, "R5 alloc");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R6 call 2");
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 1, 40, 3, 0, 0, 0, "R5 alloc nest");
      acc(1, 72, "R3 nest edge");
      step(1, 0, 0, 0, 0, 1, 0, 100, "R6 nested call");
      acc(0, 127, "R2 wrap");
      acc(1, 33, "R2 nest map");
    end
    step(1, 0, 0, 0, 0, 0, 0, 0, "R8 call on full stack");
    acc(0, 32, "R8 marker kept");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R9 return beats call");
    acc(0, 40, "R9 after pop");
    for (int i = 0; i < 7; i++) begin
      step(0, 1, 0, 0, 0, 1, 0, 45, "R7 unwind");
      acc(1, 50, "R7 restored map");
    end
    step(0, 1, 0, 0, 0, 0, 0, 0, "R8 return on empty");
    acc(0, 33, "R8 marker kept");
    step(0, 0, 1, 60, 40, 0, 0, 0, "R5 oversize alloc");
    acc(1, 36, "R5 sizes kept");
    step(0, 0, 1, 90, 6, 0, 0, 0, "R5 full-size alloc");
    acc(1, 127, "R2 R3 max arch");
    step(1, 0, 1, 5, 5, 0, 0, 0, "R9 call beats alloc");
    acc(1, 32, "R9 callee");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R7 return");
    acc(0, 100, "R7 final");
    step(0, 0, 0, 0, 0, 0, 0, 0, "idle");
    @(posedge clk);
    #2;
    acc_valid = 0;
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule